// File: doc/BRIEF.md
# Transactional Coherence Directory

This block is the directory controller for a small multicore whose cores each have a direct-mapped private L1. It tracks every cached line with a tag, an MSI state and a presence vector holding one bit per core. It orders the coherence traffic the cores send it. Requests made outside a transaction follow plain MSI: owners are downgraded or invalidated, and sharers are invalidated before a writer is acknowledged. Requests made inside a hardware transaction are first checked against the lines that other running transactions hold. A conflicting request is answered with an abort instead of being serviced.

Each core posts one request at a time as a single-cycle pulse and then waits for either an acknowledge or an abort. The controller keeps a transaction-active flag for each core. A transaction end or abort removes that core from every presence vector, and an entry is freed once no core remains in it. A line that the directory does not hold is fetched through the victim-cache port. Data movement is not part of the block: it only raises the fetch, writeback and command strobes that a data path would act on.

Top module: `txn_dir`

## Requirements
- R1: A begin pulse sets the core's bit in `txActive`. An end or abort pulse clears it, and end/abort wins over a begin pulse in the same cycle. The flag is visible one cycle after the pulse.
- R2: Request types are encoded 0 = load miss, 1 = store miss, 2 = store hit on a shared line (upgrade). A pulse on `reqValid` is held as pending until the core gets exactly one `ackOut` or `abortOut` pulse. A new pulse from a core that is still pending is ignored.
- R3: For a core with its flag set, a store miss or upgrade conflicts when another flagged core is present on the line in S or M. A load miss conflicts only when another flagged core holds the line in M.
- R4: A conflicting request gets an `abortOut` pulse and no `ackOut`. It clears the requester's flag, removes the requester from every presence vector, and changes nothing else.
- R5: A serviced request gets an `ackOut` pulse. A load or store miss with no owner to forward from also raises `fetchOut` with `fetchAddr`. An upgrade raises no fetch.
- R6: When a load miss finds another core owning the line in M, that owner gets a `dgOut` downgrade, `wbOut` is raised, and the line ends in S. A store miss or upgrade sends `invOut` to every other holder, raises `wbOut` if one of them was the M owner, and leaves the requester sole owner in M.
- R7: On a transaction end or abort, the core is removed from every presence vector, and an entry left with no core is freed. A later miss on that line then goes to the victim-cache port.
- R8: A fetch for a line absent from the directory sets `fetchVcOut` = 1. A fetch for a line present only as shared sets `fetchVcOut` = 0 (backing memory).
- R9: At most one request is answered per cycle. Pending cores are granted in round-robin order, starting after the last granted core. A lone request is answered two clock edges after its pulse.
- R10: No request is granted in a cycle where any end or abort pulse is present.
- R11: When a request is serviced, the requesting core is first removed from any other line of the same set, because its direct-mapped L1 drops that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | One-cycle request pulse per core |
| reqType | input | 2*NUM_CORES | Request type per core (0 load, 1 store, 2 upgrade) |
| reqAddr | input | ADDR_W*NUM_CORES | Line address per core |
| txBegin | input | NUM_CORES | Transaction begin pulse per core |
| txEnd | input | NUM_CORES | Transaction commit pulse per core |
| txAbort | input | NUM_CORES | Transaction abort pulse per core |
| ackOut | output | NUM_CORES | Request serviced |
| abortOut | output | NUM_CORES | Request aborted on conflict |
| invOut | output | NUM_CORES | Invalidate command per core |
| dgOut | output | NUM_CORES | Downgrade-to-shared command per core |
| wbOut | output | 1 | Owner line written back to memory |
| fetchOut | output | 1 | Line fetch request |
| fetchVcOut | output | 1 | Fetch targets the victim-cache port |
| fetchAddr | output | ADDR_W | Address of the fetched line |
| txActive | output | NUM_CORES | Per-core in-transaction flag |

## Verification
A request pulse driven before rising edge k is captured as pending at edge k. When no other core competes, it is answered at edge k+1, with every response strobe registered there for exactly one cycle. A transaction flag changes at the edge that samples its pulse. The bench drives inputs on falling edges and samples on the falling edge after the second rising edge, so each step is checked in the single cycle its pulses exist. The round-robin and stall tests step forward one falling edge at a time and expect one more grant at each edge, pushed back by one edge where a cleanup pulse intervenes.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_STORE = 2'd1,
    RQ_UPG   = 2'd2
  } req_e;

  // strobes from control to the entry store
  typedef struct packed {
    logic        update;     // apply a serviced request
    line_state_e newState;   // state of the target line afterwards
    logic        keepOthers; // keep other sharers (load) or drop them (store)
  } dir_strobe_t;

endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int SET_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    lookupAddr,
  input  logic [NUM_CORES-1:0] reqMask,
  input  dir_strobe_t          strobe,
  input  logic [NUM_CORES-1:0] cleanMask,
  output logic                 hit,
  output line_state_e          hitState,
  output logic [NUM_CORES-1:0] hitPres
);
  localparam int TAG_W = ADDR_W - SET_BITS;
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAYS  = NUM_CORES;
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;

  line_state_e          entState [SETS][WAYS];
  logic [TAG_W-1:0]     entTag   [SETS][WAYS];
  logic [NUM_CORES-1:0] entPres  [SETS][WAYS];

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    tagIn;
  logic [WAYS-1:0]     match, freeAfter;
  logic [WW-1:0]       hitWay, allocWay;
  logic                anyFree;

  assign setIdx = lookupAddr[SET_BITS-1:0];
  assign tagIn  = lookupAddr[ADDR_W-1:SET_BITS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = (entState[setIdx][w] != ST_I) && (entTag[setIdx][w] == tagIn);
    // free once the requester's implicit eviction is applied
    assign freeAfter[w] = (entState[setIdx][w] == ST_I) ||
                          (!match[w] && ((entPres[setIdx][w] & ~reqMask) == '0));
  end

  always_comb begin
    hit = 1'b0; hitWay = '0; hitState = ST_I; hitPres = '0;
    anyFree = 1'b0; allocWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit = 1'b1; hitWay = WW'(w);
        hitState = entState[setIdx][w]; hitPres = entPres[setIdx][w];
      end
      if (freeAfter[w]) begin
        anyFree = 1'b1; allocWay = WW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          entState[s][w] <= ST_I;
          entTag[s][w]   <= '0;
          entPres[s][w]  <= '0;
        end
    end else if (strobe.update) begin
      // implicit eviction from the direct-mapped L1 (R11)
      for (int w = 0; w < WAYS; w++) begin
        if (!match[w] && entState[setIdx][w] != ST_I) begin
          entPres[setIdx][w] <= entPres[setIdx][w] & ~reqMask;
          if ((entPres[setIdx][w] & ~reqMask) == '0) entState[setIdx][w] <= ST_I;
        end
      end
      if (hit) begin
        entState[setIdx][hitWay] <= strobe.newState;
        entPres[setIdx][hitWay]  <= strobe.keepOthers ? (hitPres | reqMask) : reqMask;
      end else begin
        entState[setIdx][allocWay] <= strobe.newState;
        entTag[setIdx][allocWay]   <= tagIn;
        entPres[setIdx][allocWay]  <= reqMask;
      end
    end else if (cleanMask != '0) begin
      // commit / abort cleanup (R7)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          entPres[s][w] <= entPres[s][w] & ~cleanMask;
          if ((entPres[s][w] & ~cleanMask) == '0) entState[s][w] <= ST_I;
        end
    end
  end

  // a miss always finds a way once the requester's old line is dropped
  assert_free_way_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && !hit) |-> anyFree);

  // a hit entry is never empty
  assert_hit_has_holder_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitPres != '0));

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqType,
  input  logic [ADDR_W*NUM_CORES-1:0] reqAddr,
  input  logic [NUM_CORES-1:0]        txBegin,
  input  logic [NUM_CORES-1:0]        txEnd,
  input  logic [NUM_CORES-1:0]        txAbort,
  input  logic                        hit,
  input  line_state_e                 hitState,
  input  logic [NUM_CORES-1:0]        hitPres,
  output logic [ADDR_W-1:0]           lookupAddr,
  output logic [NUM_CORES-1:0]        reqMask,
  output dir_strobe_t                 strobe,
  output logic [NUM_CORES-1:0]        cleanMask,
  output logic [NUM_CORES-1:0]        ackOut,
  output logic [NUM_CORES-1:0]        abortOut,
  output logic [NUM_CORES-1:0]        invOut,
  output logic [NUM_CORES-1:0]        dgOut,
  output logic                        wbOut,
  output logic                        fetchOut,
  output logic                        fetchVcOut,
  output logic [ADDR_W-1:0]           fetchAddr,
  output logic [NUM_CORES-1:0]        txActive
);
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0] pend, inTx, txStop, others;
  req_e                 pendType [NUM_CORES];
  logic [ADDR_W-1:0]    pendAddr [NUM_CORES];
  logic [CW-1:0]        rrPtr, gIdx;
  logic                 gFound, grantValid, conflict, ownerFwd, isLoad;
  req_e                 gType;

  assign txStop = txEnd | txAbort;

  // round-robin pick starting at rrPtr (R9)
  always_comb begin
    gFound = 1'b0; gIdx = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      int j;
      j = (int'(rrPtr) + i) % NUM_CORES;
      if (!gFound && pend[j]) begin
        gFound = 1'b1; gIdx = CW'(j);
      end
    end
  end

  assign grantValid = gFound && (txStop == '0);   // R10
  assign reqMask    = grantValid ? (NUM_CORES'(1) << gIdx) : '0;
  assign lookupAddr = pendAddr[gIdx];
  assign gType      = pendType[gIdx];
  assign isLoad     = (gType == RQ_LOAD);
  assign others     = hit ? (hitPres & ~reqMask) : '0;
  assign ownerFwd   = hit && (hitState == ST_M) && (others != '0);
  // transactional conflict (R3)
  assign conflict   = grantValid && inTx[gIdx] && ((others & inTx) != '0) &&
                      (isLoad ? (hitState == ST_M) : hit);

  assign strobe.update     = grantValid && !conflict;
  assign strobe.newState   = isLoad ? ST_S : ST_M;
  assign strobe.keepOthers = isLoad;
  assign cleanMask         = txStop | (conflict ? reqMask : '0);
  assign txActive          = inTx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0; inTx <= '0; rrPtr <= '0;
      ackOut <= '0; abortOut <= '0; invOut <= '0; dgOut <= '0;
      wbOut <= 1'b0; fetchOut <= 1'b0; fetchVcOut <= 1'b0; fetchAddr <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        pendType[i] <= RQ_LOAD; pendAddr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CORES; i++) begin
        if (reqValid[i] && !pend[i]) begin
          pendType[i] <= req_e'(reqType[2*i +: 2]);
          pendAddr[i] <= reqAddr[ADDR_W*i +: ADDR_W];
        end
        pend[i] <= (pend[i] && !reqMask[i]) || (reqValid[i] && !pend[i]);
      end
      inTx <= (inTx | txBegin) & ~cleanMask;
      if (grantValid) rrPtr <= CW'((int'(gIdx) + 1) % NUM_CORES);
      ackOut     <= strobe.update ? reqMask : '0;
      abortOut   <= conflict ? reqMask : '0;
      invOut     <= (strobe.update && !isLoad) ? others : '0;
      dgOut      <= (strobe.update && isLoad && ownerFwd) ? others : '0;
      wbOut      <= strobe.update && ownerFwd;
      fetchOut   <= strobe.update && (gType != RQ_UPG) && !ownerFwd;
      fetchVcOut <= strobe.update && (gType != RQ_UPG) && !ownerFwd && !hit;
      fetchAddr  <= lookupAddr;
    end
  end

  assert_one_reply_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut | abortOut));

  assert_abort_drops_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut != '0) |-> ((abortOut & txActive) == '0));

  assert_flag_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txStop != '0) |=> ((txActive & $past(txStop)) == '0));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txStop != '0) |=> ((ackOut | abortOut) == '0));

  assert_vc_is_fetch_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchVcOut |-> fetchOut);

  assert_inv_not_self_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((invOut | dgOut) & ackOut) == '0);

endmodule

// File: rtl/txn_dir.sv
module txn_dir
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int SET_BITS  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqType,
  input  logic [ADDR_W*NUM_CORES-1:0] reqAddr,
  input  logic [NUM_CORES-1:0]        txBegin,
  input  logic [NUM_CORES-1:0]        txEnd,
  input  logic [NUM_CORES-1:0]        txAbort,
  output logic [NUM_CORES-1:0]        ackOut,
  output logic [NUM_CORES-1:0]        abortOut,
  output logic [NUM_CORES-1:0]        invOut,
  output logic [NUM_CORES-1:0]        dgOut,
  output logic                        wbOut,
  output logic                        fetchOut,
  output logic                        fetchVcOut,
  output logic [ADDR_W-1:0]           fetchAddr,
  output logic [NUM_CORES-1:0]        txActive
);
  logic [ADDR_W-1:0]    lookupAddr;
  logic [NUM_CORES-1:0] reqMask, cleanMask, hitPres;
  dir_strobe_t          strobe;
  logic                 hit;
  line_state_e          hitState;

  dir_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .txBegin(txBegin), .txEnd(txEnd), .txAbort(txAbort),
    .hit(hit), .hitState(hitState), .hitPres(hitPres),
    .lookupAddr(lookupAddr), .reqMask(reqMask), .strobe(strobe),
    .cleanMask(cleanMask), .ackOut(ackOut), .abortOut(abortOut),
    .invOut(invOut), .dgOut(dgOut), .wbOut(wbOut), .fetchOut(fetchOut),
    .fetchVcOut(fetchVcOut), .fetchAddr(fetchAddr), .txActive(txActive)
  );

  dir_store #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .SET_BITS(SET_BITS)) u_store (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .reqMask(reqMask),
    .strobe(strobe), .cleanMask(cleanMask),
    .hit(hit), .hitState(hitState), .hitPres(hitPres)
  );

endmodule

// File: tb/txn_dir_tb.sv
module txn_dir_tb;
  localparam int N  = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]    reqValid = '0, txBegin = '0, txEnd = '0, txAbort = '0;
  logic [2*N-1:0]  reqType = '0;
  logic [AW*N-1:0] reqAddr = '0;
  logic [N-1:0]    ackOut, abortOut, invOut, dgOut, txActive;
  logic            wbOut, fetchOut, fetchVcOut;
  logic [AW-1:0]   fetchAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  txn_dir #(.NUM_CORES(N), .ADDR_W(AW), .SET_BITS(2)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .txBegin(txBegin), .txEnd(txEnd), .txAbort(txAbort),
    .ackOut(ackOut), .abortOut(abortOut), .invOut(invOut), .dgOut(dgOut),
    .wbOut(wbOut), .fetchOut(fetchOut), .fetchVcOut(fetchVcOut),
    .fetchAddr(fetchAddr), .txActive(txActive)
  );

  // op: 0 request, 1 begin, 2 end, 3 abort. rt: 0 load, 1 store, 2 upgrade
  typedef struct packed {
    logic [1:0] op;  logic [1:0] core; logic [1:0] rt; logic [7:0] addr;
    logic [3:0] eAck; logic [3:0] eAbt; logic [3:0] eInv; logic [3:0] eDg;
    logic eWb; logic eFet; logic eVc; logic [3:0] eTx; logic [3:0] rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0,2'd0,2'd0,8'h04, 4'b0001,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd8},  // R8 cold miss
    '{2'd0,2'd1,2'd0,8'h04, 4'b0010,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b0, 4'b0000, 4'd8},  // R8 shared hit
    '{2'd0,2'd1,2'd2,8'h04, 4'b0010,4'b0,4'b0001,4'b0, 1'b0,1'b0,1'b0, 4'b0000, 4'd5},  // R5 upgrade
    '{2'd0,2'd0,2'd0,8'h04, 4'b0001,4'b0,4'b0,4'b0010, 1'b1,1'b0,1'b0, 4'b0000, 4'd6},  // R6 downgrade
    '{2'd0,2'd0,2'd1,8'h04, 4'b0001,4'b0,4'b0010,4'b0, 1'b0,1'b1,1'b0, 4'b0000, 4'd6},  // R6 inval sharer
    '{2'd0,2'd1,2'd1,8'h04, 4'b0010,4'b0,4'b0001,4'b0, 1'b1,1'b0,1'b0, 4'b0000, 4'd6},  // R6 owner steal
    '{2'd1,2'd0,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0001, 4'd1},  // R1 begin
    '{2'd1,2'd1,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0011, 4'd1},  // R1 begin
    '{2'd0,2'd0,2'd0,8'h05, 4'b0001,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0011, 4'd3},  // R3 tx load
    '{2'd0,2'd1,2'd0,8'h05, 4'b0010,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b0, 4'b0011, 4'd3},  // R3 load on S ok
    '{2'd2,2'd0,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0010, 4'd1},  // R1 end
    '{2'd2,2'd1,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0000, 4'd1},  // R1 end
    '{2'd1,2'd0,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0001, 4'd1},
    '{2'd1,2'd1,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0011, 4'd1},
    '{2'd0,2'd0,2'd1,8'h05, 4'b0001,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0011, 4'd7},  // R7 freed by commits
    '{2'd0,2'd1,2'd0,8'h05, 4'b0,4'b0010,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0001, 4'd4},  // R4 load vs tx M
    '{2'd0,2'd1,2'd0,8'h05, 4'b0010,4'b0,4'b0,4'b0001, 1'b1,1'b0,1'b0, 4'b0001, 4'd6},  // R6 normal mode
    '{2'd1,2'd1,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0011, 4'd1},
    '{2'd0,2'd1,2'd2,8'h05, 4'b0,4'b0010,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0001, 4'd3},  // R3 upgrade vs tx S
    '{2'd3,2'd0,2'd0,8'h00, 4'b0,4'b0,4'b0,4'b0, 1'b0,1'b0,1'b0, 4'b0000, 4'd1},  // R1 abort
    '{2'd0,2'd1,2'd0,8'h05, 4'b0010,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd7},  // R7 cleanup freed
    '{2'd0,2'd1,2'd0,8'h08, 4'b0010,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd8},
    '{2'd0,2'd0,2'd0,8'h04, 4'b0001,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd7},  // R7 end dropped line
    '{2'd0,2'd0,2'd0,8'h0C, 4'b0001,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd11}, // R11 evicts 04
    '{2'd0,2'd1,2'd1,8'h04, 4'b0010,4'b0,4'b0,4'b0, 1'b0,1'b1,1'b1, 4'b0000, 4'd11}  // R11 no inval
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic postReq(input int c, input logic [1:0] t, input logic [7:0] a);
    reqValid[c] = 1'b1;
    reqType[2*c +: 2] = t;
    reqAddr[AW*c +: AW] = a;
  endtask

  task automatic clearIn();
    reqValid = '0; txBegin = '0; txEnd = '0; txAbort = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R1, R2)
    chk("R1 reset txActive", 32'(txActive), 32'h0);
    chk("R2 reset ack/abort", 32'(ackOut | abortOut), 32'h0);
    chk("R5 reset fetch", 32'({fetchOut, wbOut, invOut, dgOut}), 32'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      string tg;
      e = VECS[v];
      tg = $sformatf("R%0d step%0d", e.rq, v);
      case (e.op)
        2'd0: postReq(int'(e.core), e.rt, e.addr);
        2'd1: txBegin[e.core] = 1'b1;
        2'd2: txEnd[e.core] = 1'b1;
        default: txAbort[e.core] = 1'b1;
      endcase
      @(negedge clk);
      clearIn();
      @(negedge clk);
      chk({tg, " ack"}, 32'(ackOut), 32'(e.eAck));
      chk({tg, " abort"}, 32'(abortOut), 32'(e.eAbt));
      chk({tg, " inv"}, 32'(invOut), 32'(e.eInv));
      chk({tg, " dg"}, 32'(dgOut), 32'(e.eDg));
      chk({tg, " wb"}, 32'(wbOut), 32'(e.eWb));
      chk({tg, " fetch"}, 32'(fetchOut), 32'(e.eFet));
      if (e.eFet) begin
        chk({tg, " fetchVc"}, 32'(fetchVcOut), 32'(e.eVc));
        chk({tg, " fetchAddr"}, 32'(fetchAddr), 32'(e.addr));
      end
      chk({tg, " txActive"}, 32'(txActive), 32'(e.eTx));
    end

    // R9 round robin: last grant was core 1, so order is 2, 0, 1
    postReq(0, 2'd0, 8'h06);
    postReq(1, 2'd0, 8'h0A);
    postReq(2, 2'd0, 8'h07);
    @(negedge clk);
    clearIn();
    @(negedge clk);
    chk("R9 rr first", 32'(ackOut), 32'h4);
    @(negedge clk);
    chk("R9 rr second", 32'(ackOut), 32'h1);
    @(negedge clk);
    chk("R9 rr third", 32'(ackOut), 32'h2);

    // R2 a repeat pulse while pending is dropped: only one reply
    postReq(3, 2'd0, 8'h03);
    @(negedge clk);
    postReq(3, 2'd0, 8'h03);
    @(negedge clk);
    clearIn();
    chk("R2 single reply", 32'(ackOut), 32'h8);
    @(negedge clk);
    chk("R2 no second reply", 32'(ackOut | abortOut), 32'h0);

    // R10 cleanup pulse stalls a pending grant by one cycle
    txBegin[3] = 1'b1;
    @(negedge clk);
    clearIn();
    postReq(1, 2'd0, 8'h0E);
    @(negedge clk);
    clearIn();
    txEnd[3] = 1'b1;
    @(negedge clk);
    clearIn();
    chk("R10 stalled", 32'(ackOut), 32'h0);
    chk("R1 end clears", 32'(txActive), 32'h0);
    @(negedge clk);
    chk("R10 granted after", 32'(ackOut), 32'h2);

    finishUp();
  end
endmodule